// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This block takes instruction bytes one at a time from instruction memory over a valid/ready handshake. It assembles each instruction's leading 16-bit control word, least significant byte first, and splits it into fields. It then collects the source operand bytes and the target operand bytes, in that order. The number of bytes each operand takes is worked out per instruction from the operand's kind and the operation size.

When the last byte of an instruction has been taken, the block pulses a completion strobe for one cycle. With that strobe it presents the decoded bundle: opcode, size, condition, both operand kinds, both operand values, and the total instruction length, which the fetch unit uses to advance the instruction pointer.

The block also checks the condition code against the zero and carry flags and drives an execute line. It flags illegal encodings as invalid, and an invalid instruction never executes. Operand dereferencing, execution and address translation belong to the blocks that follow.

Top module: `ifd_decoder`

## Requirements
- R1: The control word is the first two bytes, low byte first. Its fields are:
  - source kind in bits 1:0
  - target kind in bits 3:2
  - condition in bits 6:4
  - a reserved bit 7
  - opcode in bits 13:8
  - size in bits 15:14

  All fields except the reserved bit appear on the outputs in the completion cycle.
- R2: Operand byte counts:
  - Kinds 0 (register) and 1 (register pointer) take one byte.
  - Kind 2 (immediate) takes 1, 2 or 4 bytes for sizes 0, 1 and 2.
  - Kind 3 (immediate pointer) takes 4 bytes at any size.
- R3: Operand values are assembled with the first received byte least significant and are zero-extended to 32 bits. An operand that the opcode does not take reads as zero.
- R4: `done` is high for exactly one cycle, the cycle after the last byte of an instruction is taken. In that cycle the bundle is valid and `instr_len` equals the number of bytes taken for the instruction, between 2 and 10.
- R5: Opcodes (hex) and the operands they take:
  - No operand: 00, 0C, 0D, 10, 1C, 1D, 20, 2A, 3A.
  - Source only: 08, 09, 0A, 11, 18, 19, 1A, 28, 29, 2C, 2D, 31, 33, 3D.
  - Source then target: 01–07, 0B, 13–17, 1B, 21–27, 32, 34, 35, 39.
  - Every other opcode is undefined.
- R6: The condition codes are:

  | Code | Execute when |
  |------|--------------|
  | 0 | always |
  | 1 | zero flag set |
  | 2 | zero flag clear |
  | 3 | carry flag set |
  | 4 | carry flag clear |
  | 5 | zero and carry both clear |
  | 6 | zero or carry set |

  `execute` is high only when the instruction is valid and its condition holds on the live `flag_z` and `flag_c`.
- R7: Any of the following marks the instruction invalid:
  - reserved bit 7 set
  - size 3
  - condition 7
  - an undefined opcode

  Such an instruction ends after its control word, with length 2, and `execute` stays low.
- R8: A register or register-pointer operand byte above 34 marks the instruction invalid. The full instruction is still consumed at its normal length.
- R9: While `rst_n` is low, `done` and `in_ready` are low. `in_ready` is high from the first clock after reset is released.
- R10: The first byte of the next instruction can be taken in the completion cycle, so instructions run back to back. Idle cycles between bytes do not change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction byte offered |
| in_data | input | 8 | Instruction byte |
| in_ready | output | 1 | Decoder takes the offered byte |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| done | output | 1 | One-cycle completion strobe |
| instr_len | output | 4 | Instruction length in bytes |
| opcode | output | 6 | Opcode field |
| op_size | output | 2 | Operation size field |
| cond | output | 3 | Condition field |
| src_kind | output | 2 | Source operand kind |
| tgt_kind | output | 2 | Target operand kind |
| src_val | output | 32 | Assembled source operand |
| tgt_val | output | 32 | Assembled target operand |
| execute | output | 1 | Condition holds and instruction valid |
| invalid | output | 1 | Illegal encoding detected |

## Verification
The bench builds the block with its defaults: 32-bit operands and 34 as the highest legal register number. With these defaults every opcode value, every size code including the reserved one, and every pairing of source and target kinds fit in one sweep of 4096 instructions.

Within that sweep the bench also:
- rotates the condition codes and flag states, so every predicate meets every flag combination;
- sets the reserved bit now and then;
- draws register bytes from a range that crosses the legal limit;
- inserts idle cycles between bytes.

A short run of instructions sent with no gap between them covers the case where a completion and the next instruction's first byte fall in the same cycle.

// File: rtl/ifd_pkg.sv
package ifd_pkg;

  typedef enum logic [1:0] {
    K_REG    = 2'd0,
    K_REGPTR = 2'd1,
    K_IMM    = 2'd2,
    K_IMMPTR = 2'd3
  } opnd_kind_e;

  typedef enum logic [1:0] {
    AR_NONE  = 2'd0,
    AR_SRC   = 2'd1,
    AR_PAIR  = 2'd2,
    AR_UNDEF = 2'd3
  } arity_e;

  typedef struct packed {
    logic [1:0] size;
    logic [5:0] opcode;
    logic       rsv;
    logic [2:0] cond;
    logic [1:0] tgt;
    logic [1:0] src;
  } ctrl_word_t;

  // Operands each opcode takes
  function automatic arity_e op_arity(input logic [5:0] op);
    case (op)
      6'h00, 6'h0C, 6'h0D, 6'h10, 6'h1C, 6'h1D,
      6'h20, 6'h2A, 6'h3A:
        return AR_NONE;
      6'h08, 6'h09, 6'h0A, 6'h11, 6'h18, 6'h19, 6'h1A,
      6'h28, 6'h29, 6'h2C, 6'h2D, 6'h31, 6'h33, 6'h3D:
        return AR_SRC;
      6'h01, 6'h02, 6'h03, 6'h04, 6'h05, 6'h06, 6'h07, 6'h0B,
      6'h13, 6'h14, 6'h15, 6'h16, 6'h17, 6'h1B,
      6'h21, 6'h22, 6'h23, 6'h24, 6'h25, 6'h26, 6'h27,
      6'h32, 6'h34, 6'h35, 6'h39:
        return AR_PAIR;
      default:
        return AR_UNDEF;
    endcase
  endfunction

  // Bytes occupied by one operand
  function automatic logic [2:0] opnd_bytes(input opnd_kind_e k, input logic [1:0] sz);
    case (k)
      K_IMM: begin
        case (sz)
          2'd0:    return 3'd1;
          2'd1:    return 3'd2;
          default: return 3'd4;
        endcase
      end
      K_IMMPTR: return 3'd4;
      default:  return 3'd1;
    endcase
  endfunction

  // Length of a well-formed instruction
  function automatic logic [3:0] instr_bytes(input ctrl_word_t cw);
    logic [3:0] n;
    arity_e     a;
    a = op_arity(cw.opcode);
    n = 4'd2;
    if (a == AR_SRC || a == AR_PAIR)
      n = n + 4'(opnd_bytes(opnd_kind_e'(cw.src), cw.size));
    if (a == AR_PAIR)
      n = n + 4'(opnd_bytes(opnd_kind_e'(cw.tgt), cw.size));
    return n;
  endfunction

  function automatic logic ctrl_bad(input ctrl_word_t cw);
    return cw.rsv || (cw.size == 2'd3) || (cw.cond == 3'd7) ||
           (op_arity(cw.opcode) == AR_UNDEF);
  endfunction

  function automatic logic cond_pass(input logic [2:0] cc, input logic z, input logic c);
    case (cc)
      3'd0:    return 1'b1;
      3'd1:    return z;
      3'd2:    return !z;
      3'd3:    return c;
      3'd4:    return !c;
      3'd5:    return !(z || c);
      3'd6:    return z || c;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ifd_cond_unit.sv
module ifd_cond_unit
  import ifd_pkg::*;
(
  input  logic [2:0] cc,
  input  logic       z,
  input  logic       c,
  input  logic       bad,
  output logic       exec
);
  assign exec = !bad && cond_pass(cc, z, c);
endmodule

// File: rtl/ifd_opnd_acc.sv
module ifd_opnd_acc #(
  parameter int OPND_W = 32,
  localparam int NBYTES = OPND_W / 8,
  localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr,
  input  logic [IDX_W-1:0]  idx,
  input  logic [7:0]        din,
  output logic [OPND_W-1:0] val
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   val <= '0;
    else if (clr) val <= '0;
    else if (wr)  val[idx*8 +: 8] <= din;
  end
endmodule

// File: rtl/ifd_seq.sv
module ifd_seq
  import ifd_pkg::*;
#(
  parameter int LAST_REG = 34,
  parameter int LEN_W    = 4,
  parameter int IDX_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             acc_clr,
  output logic             src_wr,
  output logic             tgt_wr,
  output logic [IDX_W-1:0] byte_idx,
  output logic             done,
  output ctrl_word_t       cw_out,
  output logic [LEN_W-1:0] len_out,
  output logic             bad_out,
  output logic             ev_take,
  output logic             ev_finish,
  output logic             ev_cw_bad
);
  typedef enum logic [1:0] {ST_LO, ST_HI, ST_SRC, ST_TGT} st_e;

  st_e              st_q, st_d;
  logic [7:0]       lo_q;
  ctrl_word_t       cw_q, cw_now;
  logic [IDX_W-1:0] cnt_q;
  logic             ready_q, regbad_q;
  arity_e           ar_now;
  opnd_kind_e       cur_kind;
  logic [2:0]       need;
  logic             in_opnd, last_byte, reg_byte_bad;

  assign ev_take  = in_valid && ready_q;
  assign in_ready = ready_q;

  always_comb begin
    if (st_q == ST_HI) cw_now = ctrl_word_t'({in_data, lo_q});
    else               cw_now = cw_q;
  end

  assign ar_now    = op_arity(cw_now.opcode);
  assign ev_cw_bad = ctrl_bad(cw_now);
  assign cur_kind  = (st_q == ST_TGT) ? opnd_kind_e'(cw_now.tgt) : opnd_kind_e'(cw_now.src);
  assign need      = opnd_bytes(cur_kind, cw_now.size);
  assign in_opnd   = (st_q == ST_SRC) || (st_q == ST_TGT);
  assign last_byte = ((3'(cnt_q) + 3'd1) == need);
  assign reg_byte_bad = in_opnd && (cur_kind == K_REG || cur_kind == K_REGPTR) &&
                        (int'(in_data) > LAST_REG);

  always_comb begin
    st_d      = st_q;
    ev_finish = 1'b0;
    if (ev_take) begin
      case (st_q)
        ST_LO: st_d = ST_HI;
        ST_HI: begin
          if (ev_cw_bad || ar_now == AR_NONE) begin
            st_d = ST_LO; ev_finish = 1'b1;
          end else begin
            st_d = ST_SRC;
          end
        end
        ST_SRC: begin
          if (last_byte) begin
            if (ar_now == AR_PAIR) st_d = ST_TGT;
            else begin st_d = ST_LO; ev_finish = 1'b1; end
          end
        end
        default: begin
          if (last_byte) begin st_d = ST_LO; ev_finish = 1'b1; end
        end
      endcase
    end
  end

  assign acc_clr  = ev_take && (st_q == ST_LO);
  assign src_wr   = ev_take && (st_q == ST_SRC);
  assign tgt_wr   = ev_take && (st_q == ST_TGT);
  assign byte_idx = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_LO;
      lo_q     <= '0;
      cw_q     <= '0;
      cnt_q    <= '0;
      ready_q  <= 1'b0;
      regbad_q <= 1'b0;
      done     <= 1'b0;
      cw_out   <= '0;
      len_out  <= '0;
      bad_out  <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      st_q    <= st_d;
      done    <= ev_finish;
      if (ev_take && st_q == ST_LO) lo_q <= in_data;
      if (ev_take && st_q == ST_HI) cw_q <= cw_now;
      if (ev_take) cnt_q <= (in_opnd && !last_byte) ? cnt_q + 1'b1 : '0;
      if (acc_clr)                      regbad_q <= 1'b0;
      else if (ev_take && reg_byte_bad) regbad_q <= 1'b1;
      if (ev_finish) begin
        cw_out  <= cw_now;
        len_out <= ev_cw_bad ? LEN_W'(2) : LEN_W'(instr_bytes(cw_now));
        bad_out <= ev_cw_bad || regbad_q || reg_byte_bad;
      end
    end
  end
endmodule

// File: rtl/ifd_decoder.sv
module ifd_decoder
  import ifd_pkg::*;
#(
  parameter int OPND_W   = 32,
  parameter int LAST_REG = 34,
  localparam int NBYTES  = OPND_W / 8,
  localparam int IDX_W   = (NBYTES > 1) ? $clog2(NBYTES) : 1,
  localparam int LEN_W   = $clog2(2 + 2 * NBYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  input  logic              flag_z,
  input  logic              flag_c,
  output logic              done,
  output logic [LEN_W-1:0]  instr_len,
  output logic [5:0]        opcode,
  output logic [1:0]        op_size,
  output logic [2:0]        cond,
  output logic [1:0]        src_kind,
  output logic [1:0]        tgt_kind,
  output logic [OPND_W-1:0] src_val,
  output logic [OPND_W-1:0] tgt_val,
  output logic              execute,
  output logic              invalid
);
  logic             acc_clr, src_wr, tgt_wr;
  logic [IDX_W-1:0] byte_idx;
  ctrl_word_t       cw_out;
  logic             ev_take, ev_finish, ev_cw_bad;
  logic [OPND_W-1:0] acc_val [2];

  ifd_seq #(.LAST_REG(LAST_REG), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .acc_clr(acc_clr), .src_wr(src_wr), .tgt_wr(tgt_wr),
    .byte_idx(byte_idx), .done(done), .cw_out(cw_out), .len_out(instr_len),
    .bad_out(invalid), .ev_take(ev_take), .ev_finish(ev_finish),
    .ev_cw_bad(ev_cw_bad)
  );

  for (genvar g = 0; g < 2; g++) begin : g_acc
    ifd_opnd_acc #(.OPND_W(OPND_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .clr(acc_clr),
      .wr((g == 0) ? src_wr : tgt_wr),
      .idx(byte_idx), .din(in_data), .val(acc_val[g])
    );
  end

  assign src_val  = acc_val[0];
  assign tgt_val  = acc_val[1];
  assign opcode   = cw_out.opcode;
  assign op_size  = cw_out.size;
  assign cond     = cw_out.cond;
  assign src_kind = cw_out.src;
  assign tgt_kind = cw_out.tgt;

  ifd_cond_unit u_cond (
    .cc(cw_out.cond), .z(flag_z), .c(flag_c), .bad(invalid), .exec(execute)
  );
endmodule

// File: rtl/ifd_decoder_chk.sv
module ifd_decoder_chk #(
  parameter int LEN_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             done,
  input logic [LEN_W-1:0] instr_len,
  input logic [1:0]       op_size,
  input logic [2:0]       cond,
  input logic             execute,
  input logic             invalid,
  input logic             ev_finish
);
  logic       take;
  logic [4:0] seen;
  assign take = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    seen <= '0;
    else if (done) seen <= take ? 5'd1 : 5'd0;
    else if (take) seen <= seen + 5'd1;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one cycle"); // R4
  AST_DONE_FOLLOWS_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    ev_finish |=> done) else $error("done missing after finish"); // R4
  AST_LEN_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (instr_len >= LEN_W'(2) && instr_len <= LEN_W'(10))) else $error("length out of range"); // R4
  AST_LEN_MATCHES_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (5'(instr_len) == seen)) else $error("length differs from bytes taken"); // R2
  AST_INVALID_NO_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    (done && invalid) |-> !execute) else $error("invalid instruction executes"); // R6
  AST_ALWAYS_EXECUTES: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cond == 3'd0 && !invalid) |-> execute) else $error("unconditional not executed"); // R6
  AST_SIZE3_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_size == 2'd3) |-> (invalid && instr_len == LEN_W'(2))) else $error("size 3 handling"); // R7
  AST_COND7_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cond == 3'd7) |-> invalid) else $error("condition 7 accepted"); // R7
endmodule

bind ifd_decoder ifd_decoder_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .done(done), .instr_len(instr_len), .op_size(op_size), .cond(cond),
  .execute(execute), .invalid(invalid), .ev_finish(ev_finish)
);

// File: tb/ifd_decoder_test.sv
module ifd_decoder_test;
  localparam logic [63:0] DEF_MASK = 64'h263E_37FF_3FFB_3FFF;
  localparam logic [63:0] SRC_MASK = 64'h223E_33FE_0FFA_0FFE;
  localparam logic [63:0] TGT_MASK = 64'h0234_00FE_08F8_08FE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic flag_z = 1'b0, flag_c = 1'b0;
  logic in_ready, done, execute, invalid;
  logic [3:0] instr_len;
  logic [5:0] opcode;
  logic [1:0] op_size, src_kind, tgt_kind;
  logic [2:0] cond;
  logic [31:0] src_val, tgt_val;

  int checks = 0;
  int errors = 0;
  int done_seen = 0;

  logic [3:0]  r_len [16];
  logic [14:0] r_cw  [16];
  logic [31:0] r_src [16];
  logic [31:0] r_tgt [16];
  logic        r_exe [16];
  logic        r_inv [16];

  always #5 clk = ~clk;

  ifd_decoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .flag_z(flag_z), .flag_c(flag_c), .done(done),
    .instr_len(instr_len), .opcode(opcode), .op_size(op_size), .cond(cond),
    .src_kind(src_kind), .tgt_kind(tgt_kind), .src_val(src_val),
    .tgt_val(tgt_val), .execute(execute), .invalid(invalid)
  );

  always @(negedge clk) begin
    if (rst_n && done) begin
      r_len[done_seen % 16] = instr_len;
      r_cw[done_seen % 16]  = {op_size, opcode, cond, tgt_kind, src_kind};
      r_src[done_seen % 16] = src_val;
      r_tgt[done_seen % 16] = tgt_val;
      r_exe[done_seen % 16] = execute;
      r_inv[done_seen % 16] = invalid;
      done_seen = done_seen + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_pass(input int cd, input bit z, input bit c);
    case (cd)
      0: return 1'b1;
      1: return z;
      2: return !z;
      3: return c;
      4: return !c;
      5: return !z && !c;
      6: return z || c;
      default: return 1'b0;
    endcase
  endfunction

  task automatic put(input logic [7:0] b, input bit stall);
    if (stall) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    @(posedge clk);
  endtask

  task automatic send_opnd(input int kind, input int sz, input int it, input int salt,
                           output logic [31:0] v, output bit rb, inout int len);
    int n;
    logic [7:0] b;
    n = (kind < 2) ? 1 : (kind == 3) ? 4 : (1 << sz);
    v = '0;
    rb = 1'b0;
    for (int k = 0; k < n; k++) begin
      if (kind < 2) b = 8'((it * 13 + salt) % 40);
      else          b = 8'((it * 37 + k * 91 + salt * 5) % 256);
      if (kind < 2 && b > 8'd34) rb = 1'b1;
      v = v | (32'(b) << (8 * k));
      put(b, (it + k) % 3 == 0);
    end
    len = len + n;
  endtask

  initial begin
    #1_500_000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int it;
    int n0;
    it = 0;
    // R9: reset state
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R9", done, 0);
    chk(in_ready == 1'b0, "R9", in_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R9", in_ready, 1);

    for (int op = 0; op < 64; op++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int st = 0; st < 4; st++) begin
          for (int tt = 0; tt < 4; tt++) begin
            int cd, len;
            bit rsv, z, c, bad_cw, rb_s, rb_t, exp_inv, exp_exe;
            logic [15:0] cw;
            logic [31:0] vs, vt;
            string tag;
            cd  = it % 8;
            rsv = (it % 29) == 5;
            z   = ((it / 8) % 2) == 1;
            c   = ((it / 16) % 2) == 1;
            flag_z = z;
            flag_c = c;
            cw = {sz[1:0], op[5:0], rsv, cd[2:0], tt[1:0], st[1:0]};
            bad_cw = rsv || sz == 3 || cd == 7 || !DEF_MASK[op];
            n0 = done_seen;
            len = 2;
            vs = '0; vt = '0; rb_s = 1'b0; rb_t = 1'b0;
            put(cw[7:0], (it % 5) == 0);
            put(cw[15:8], 1'b0);
            if (!bad_cw && SRC_MASK[op]) send_opnd(st, sz, it, 1, vs, rb_s, len);
            if (!bad_cw && TGT_MASK[op]) send_opnd(tt, sz, it, 7, vt, rb_t, len);
            @(negedge clk);
            in_valid = 1'b0;
            #1;
            exp_inv = bad_cw || rb_s || rb_t;
            exp_exe = !exp_inv && exp_pass(cd, z, c);
            tag = bad_cw ? "R7" : (rb_s || rb_t) ? "R8" : "R5";
            chk(done_seen == n0 + 1, "R4", done_seen - n0, 1);
            chk(r_len[n0 % 16] == 4'(len), "R2", r_len[n0 % 16], len);
            chk(r_cw[n0 % 16] == {cw[15:8], cw[6:0]}, "R1", r_cw[n0 % 16], {cw[15:8], cw[6:0]});
            chk(r_src[n0 % 16] == vs, "R3", r_src[n0 % 16], vs);
            chk(r_tgt[n0 % 16] == vt, "R3", r_tgt[n0 % 16], vt);
            chk(r_inv[n0 % 16] == exp_inv, tag, r_inv[n0 % 16], exp_inv);
            chk(r_exe[n0 % 16] == exp_exe, "R6", r_exe[n0 % 16], exp_exe);
            it++;
          end
        end
      end
    end

    // R10: three instructions with no gap
    flag_z = 1'b0; flag_c = 1'b0;
    n0 = done_seen;
    put(8'h00, 1'b0); put(8'h00, 1'b0);
    put(8'h00, 1'b0); put(8'h97, 1'b0); put(8'h05, 1'b0); put(8'h21, 1'b0);
    put(8'h02, 1'b0); put(8'h41, 1'b0); put(8'h34, 1'b0); put(8'h12, 1'b0); put(8'h03, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk(done_seen == n0 + 3, "R10", done_seen - n0, 3);
    chk(r_len[n0 % 16] == 4'd2, "R10", r_len[n0 % 16], 2);
    chk(r_len[(n0 + 1) % 16] == 4'd4, "R10", r_len[(n0 + 1) % 16], 4);
    chk(r_src[(n0 + 1) % 16] == 32'h5 && r_tgt[(n0 + 1) % 16] == 32'h21, "R10",
        r_src[(n0 + 1) % 16], 32'h5);
    chk(r_len[(n0 + 2) % 16] == 4'd5, "R10", r_len[(n0 + 2) % 16], 5);
    chk(r_src[(n0 + 2) % 16] == 32'h1234 && r_tgt[(n0 + 2) % 16] == 32'h3, "R10",
        r_src[(n0 + 2) % 16], 32'h1234);
    chk(r_exe[(n0 + 2) % 16] == 1'b1 && r_inv[(n0 + 2) % 16] == 1'b0, "R10",
        r_exe[(n0 + 2) % 16], 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule